// File: doc/BRIEF.md
# Serial LED Status Streamer

This block sends the status of eight network ports to an external serial-in LED driver over two wires: a gated LED clock and a data line. Each port has three status bits: duplex/collision, speed and link/activity. The block packs the 24 bits into one burst. In a burst, every bit gets one clock pulse that is short and high, preceded by a long low phase. The data line changes only when the clock falls, so the receiver can latch each bit on the rising edge.

At the start of every burst, all 24 input bits are copied into a holding register. The stream therefore stays self-consistent while the status inputs move. After the last pulse, both lines stay low for a long idle gap, and then the next burst begins. The pulse shape and the gap length are parameters counted in system clock cycles. The defaults assume a 40 ns system clock: a pulse of 40 ns high after 600 ns low, and a gap of 1,000,000 cycles, which is 40 ms. Both outputs come straight from flip-flops.

Top module: `led_status_streamer`

## Requirements
- R1: While reset is asserted, and during the idle gap after reset or after a burst, the LED clock and the LED data line are both held at 0.
- R2: After reset is released, the LED clock first rises on the (GAP_CYC + LOW_CYC + 1)-th system clock edge.
- R3: Within a burst, each LED clock pulse stays high for exactly HIGH_CYC cycles, and the clock is low for exactly LOW_CYC cycles between two consecutive pulses.
- R4: Every burst has exactly 24 rising edges on the LED clock. No 25th pulse follows before the idle gap.
- R5: Stream position k (k = 0 is latched by the first rising edge) carries the following bit. For k in 0..7 it is duplex bit k. For k in 8..15 it is speed bit k-8. For k in 16..23 it is link bit k-16. Equivalently, the stream is the vector {link, speed, duplex} sent LSB first.
- R6: The data line never changes in a cycle where the LED clock is high, and it is constant through each low phase of a burst. It changes only together with a falling clock edge, at the start of a burst, or at its end.
- R7: The first bit of a burst is on the data line LOW_CYC cycles before the first rising edge of that burst.
- R8: After the last falling edge of a burst, the LED clock stays low for GAP_CYC + LOW_CYC cycles. The data line is 0 for the first GAP_CYC of those cycles.
- R9: The status inputs are sampled once, when a burst starts. Changes during a burst do not appear until the next burst.
- R10: Asserting reset in the middle of a burst ends it at once. After release, timing restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_duplex_i | input | NUM_PORTS | Duplex/collision status, one bit per port |
| port_speed_i | input | NUM_PORTS | Speed status, one bit per port |
| port_link_i | input | NUM_PORTS | Link/activity status, one bit per port |
| sled_clk_o | output | 1 | Gated LED shift clock, registered |
| sled_dat_o | output | 1 | LED serial data, registered |

## Verification
The bench sends the first status bit as a 1 and measures the data line during the lead-in. A design that presents the first bit late, with no setup before the first rise, shifts the first nonzero sample. A design that drives data during the gap breaks the zero run. Both fault the R7 and R8 counts. It changes inputs halfway through a burst: a design that reads the live inputs instead of a snapshot shows the new pattern too early. It counts pulse widths and the gap in samples, so an off-by-one in the pulse or low counters, or a 25th pulse, shows up as a wrong width or a short lead. A reset mid-burst has to drop both lines on the next edge and restart the full lead-in.

// File: rtl/led_stream_pkg.sv
package led_stream_pkg;

  typedef enum logic {
    ST_GAP   = 1'b0,
    ST_BURST = 1'b1
  } stream_state_e;

  localparam int STATUS_GROUPS = 3;

endpackage

// File: rtl/led_gap_timer.sv
module led_gap_timer #(
  parameter int GAP_CYC = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);

  localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R2
  gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= CNT_LAST));

endmodule

// File: rtl/led_bit_timer.sv
module led_bit_timer #(
  parameter int LOW_CYC  = 15,
  parameter int HIGH_CYC = 1,
  parameter int NUM_BITS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic high_phase,
  output logic bit_adv,
  output logic burst_end
);

  localparam int PERIOD = LOW_CYC + HIGH_CYC;
  localparam int SW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int BW     = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(PERIOD - 1);
  localparam logic [SW-1:0] SUB_RISE = SW'(LOW_CYC);
  localparam logic [BW-1:0] BIT_LAST = BW'(NUM_BITS - 1);

  logic [SW-1:0] sub_q;
  logic [BW-1:0] bit_q;
  logic          wrap;

  assign wrap       = run && (sub_q == SUB_LAST);
  assign high_phase = run && (sub_q >= SUB_RISE);
  assign bit_adv    = wrap && (bit_q != BIT_LAST);
  assign burst_end  = wrap && (bit_q == BIT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sub_q <= '0;
      bit_q <= '0;
    end else if (wrap) begin
      sub_q <= '0;
      bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + BW'(1);
    end else begin
      sub_q <= sub_q + SW'(1);
    end
  end

  // R3
  sub_range_chk: assert property (@(posedge clk) disable iff (rst)
    sub_q <= SUB_LAST);

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_q <= BIT_LAST);

endmodule

// File: rtl/led_shift_hold.sv
module led_shift_hold #(
  parameter int NUM_BITS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [NUM_BITS-1:0] load_val,
  input  logic                shift,
  output logic                head
);

  logic [NUM_BITS-1:0] hold_q;

  assign head = hold_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (load) begin
      hold_q <= load_val;
    end else if (shift) begin
      hold_q <= {1'b0, hold_q[NUM_BITS-1:1]};
    end
  end

endmodule

// File: rtl/led_status_streamer.sv
module led_status_streamer
  import led_stream_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int LOW_CYC   = 15,
  parameter int HIGH_CYC  = 1,
  parameter int GAP_CYC   = 1000000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] port_duplex_i,
  input  logic [NUM_PORTS-1:0] port_speed_i,
  input  logic [NUM_PORTS-1:0] port_link_i,
  output logic                 sled_clk_o,
  output logic                 sled_dat_o
);

  localparam int NUM_BITS = STATUS_GROUPS * NUM_PORTS;

  stream_state_e       state_q;
  logic                gap_done;
  logic                high_phase;
  logic                bit_adv;
  logic                burst_end;
  logic                head;
  logic [NUM_BITS-1:0] snap;

  // Stream order: duplex group first, then speed, then link; port 0 leads each group.
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_pack
    assign snap[g]               = port_duplex_i[g];
    assign snap[NUM_PORTS + g]   = port_speed_i[g];
    assign snap[2*NUM_PORTS + g] = port_link_i[g];
  end

  led_gap_timer #(
    .GAP_CYC (GAP_CYC)
  ) u_gap (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ST_GAP),
    .done (gap_done)
  );

  led_bit_timer #(
    .LOW_CYC  (LOW_CYC),
    .HIGH_CYC (HIGH_CYC),
    .NUM_BITS (NUM_BITS)
  ) u_bits (
    .clk        (clk),
    .rst        (rst),
    .run        (state_q == ST_BURST),
    .high_phase (high_phase),
    .bit_adv    (bit_adv),
    .burst_end  (burst_end)
  );

  led_shift_hold #(
    .NUM_BITS (NUM_BITS)
  ) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (gap_done),
    .load_val (snap),
    .shift    (bit_adv),
    .head     (head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_GAP;
    end else begin
      case (state_q)
        ST_GAP:   if (gap_done)  state_q <= ST_BURST;
        ST_BURST: if (burst_end) state_q <= ST_GAP;
        default:                 state_q <= ST_GAP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sled_clk_o <= 1'b0;
      sled_dat_o <= 1'b0;
    end else begin
      sled_clk_o <= high_phase;
      sled_dat_o <= (state_q == ST_BURST) && head;
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP) && $past(state_q == ST_GAP) |-> !sled_clk_o && !sled_dat_o);

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sled_clk_o |-> $stable(sled_dat_o));

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BURST) && $past(state_q == ST_BURST) && !$past(bit_adv) |-> $stable(head));

endmodule

// File: tb/led_status_streamer_tb.sv
module led_status_streamer_tb;

  localparam int NP  = 8;
  localparam int LO  = 15;
  localparam int HI  = 1;
  localparam int GAP = 100;
  localparam int NB  = 3 * NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] dup = '0;
  logic [NP-1:0] spd = '0;
  logic [NP-1:0] lnk = '0;
  logic          led_clk;
  logic          led_dat;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  led_status_streamer #(
    .NUM_PORTS (NP),
    .LOW_CYC   (LO),
    .HIGH_CYC  (HI),
    .GAP_CYC   (GAP)
  ) u_dut (
    .clk           (clk),
    .rst           (rst),
    .port_duplex_i (dup),
    .port_speed_i  (spd),
    .port_link_i   (lnk),
    .sled_clk_o    (led_clk),
    .sled_dat_o    (led_dat)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Collect one full burst. Returns after the sample at the 24th falling edge.
  task automatic get_burst(input int change_at, input logic [NP-1:0] nd,
                           input logic [NP-1:0] ns, input logic [NP-1:0] nl,
                           output logic [NB-1:0] got, output int lead,
                           output int first_nz, output logic pre_bit,
                           output int hi_bad, output int lo_bad, output int stab_bad);
    logic dref;
    int   hcnt;
    int   lcnt;
    got = '0; lead = 0; first_nz = -1; pre_bit = 1'b0;
    hi_bad = 0; lo_bad = 0; stab_bad = 0;
    while (led_clk !== 1'b1) begin
      pre_bit = led_dat;
      tick();
      lead++;
      if (led_dat === 1'b1 && first_nz < 0) first_nz = lead;
    end
    for (int k = 0; k < NB; k++) begin
      got[k] = led_dat;
      if (k == change_at) begin
        dup = nd; spd = ns; lnk = nl;
      end
      hcnt = 1;
      dref = led_dat;
      tick();
      while (led_clk === 1'b1) begin
        hcnt++;
        if (led_dat !== dref) stab_bad++;
        tick();
      end
      if (hcnt != HI) hi_bad++;
      if (k < NB - 1) begin
        lcnt = 1;
        dref = led_dat;
        tick();
        while (led_clk !== 1'b1) begin
          lcnt++;
          if (led_dat !== dref) stab_bad++;
          tick();
        end
        if (led_dat !== dref) stab_bad++;
        if (lcnt != LO) lo_bad++;
      end
    end
  endtask

  task automatic apply_reset(input logic [NP-1:0] d, input logic [NP-1:0] s,
                             input logic [NP-1:0] l);
    rst = 1'b1;
    dup = d; spd = s; lnk = l;
    repeat (4) tick();
    // R1: lines low while reset is held
    check(led_clk === 1'b0, "R1", "clk in reset", led_clk, 0);
    check(led_dat === 1'b0, "R1", "data in reset", led_dat, 0);
    rst = 1'b0;
  endtask

  task automatic t_first_burst();
    logic [NB-1:0] got;
    int lead, fnz, hb, lb, sb;
    logic pre;
    apply_reset(8'hA5, 8'h3C, 8'h81);
    get_burst(-1, '0, '0, '0, got, lead, fnz, pre, hb, lb, sb);
    check(lead == GAP + LO + 1, "R2", "first rise cycle", lead, GAP + LO + 1);
    check(fnz == GAP + 1, "R1", "data low through initial gap", fnz, GAP + 1);
    check(pre === 1'b1, "R7", "first bit set before first rise", pre, 1);
    check(got == {8'h81, 8'h3C, 8'hA5}, "R5", "bit order", got, {8'h81, 8'h3C, 8'hA5});
    check(hb == 0, "R3", "high width errors", hb, 0);
    check(lb == 0, "R3", "low width errors", lb, 0);
    check(sb == 0, "R6", "data moved off falling edge", sb, 0);
  endtask

  task automatic t_gap_and_count();
    logic [NB-1:0] got;
    int lead, fnz, hb, lb, sb;
    logic pre;
    get_burst(-1, '0, '0, '0, got, lead, fnz, pre, hb, lb, sb);
    check(lead == GAP + LO, "R8", "low span after last fall", lead, GAP + LO);
    check(lead == GAP + LO, "R4", "no 25th pulse", lead, GAP + LO);
    check(fnz == GAP, "R8", "data low during gap", fnz, GAP);
    check(got == {8'h81, 8'h3C, 8'hA5}, "R5", "repeat burst", got, {8'h81, 8'h3C, 8'hA5});
    check(sb == 0, "R6", "stability repeat burst", sb, 0);
  endtask

  task automatic t_patterns();
    logic [NB-1:0] got;
    int lead, fnz, hb, lb, sb;
    logic pre;
    dup = 8'hFF; spd = 8'h00; lnk = 8'hFF;
    get_burst(-1, '0, '0, '0, got, lead, fnz, pre, hb, lb, sb);
    check(got == {8'hFF, 8'h00, 8'hFF}, "R5", "groups ones/zeros", got, {8'hFF, 8'h00, 8'hFF});
    check(hb == 0 && lb == 0, "R3", "widths pattern 2", hb + lb, 0);
    dup = 8'h01; spd = 8'h80; lnk = 8'h40;
    get_burst(-1, '0, '0, '0, got, lead, fnz, pre, hb, lb, sb);
    check(got == {8'h40, 8'h80, 8'h01}, "R5", "single bits", got, {8'h40, 8'h80, 8'h01});
    check(sb == 0, "R6", "stability pattern 3", sb, 0);
  endtask

  task automatic t_snapshot();
    logic [NB-1:0] got;
    int lead, fnz, hb, lb, sb;
    logic pre;
    dup = 8'h0F; spd = 8'hF0; lnk = 8'h55;
    get_burst(5, 8'hF0, 8'h0F, 8'hAA, got, lead, fnz, pre, hb, lb, sb);
    check(got == {8'h55, 8'hF0, 8'h0F}, "R9", "mid-burst change ignored", got, {8'h55, 8'hF0, 8'h0F});
    get_burst(-1, '0, '0, '0, got, lead, fnz, pre, hb, lb, sb);
    check(got == {8'hAA, 8'h0F, 8'hF0}, "R9", "next burst takes new inputs", got, {8'hAA, 8'h0F, 8'hF0});
  endtask

  task automatic t_abort();
    logic [NB-1:0] got;
    int lead, fnz, hb, lb, sb;
    logic pre;
    while (led_clk !== 1'b1) tick();
    repeat (40) tick();
    rst = 1'b1;
    tick();
    check(led_clk === 1'b0 && led_dat === 1'b0, "R10", "lines after mid-burst reset",
          {led_clk, led_dat}, 0);
    rst = 1'b0;
    dup = 8'hC3; spd = 8'h18; lnk = 8'h7E;
    get_burst(-1, '0, '0, '0, got, lead, fnz, pre, hb, lb, sb);
    check(lead == GAP + LO + 1, "R10", "restart timing", lead, GAP + LO + 1);
    check(got == {8'h7E, 8'h18, 8'hC3}, "R10", "restart data", got, {8'h7E, 8'h18, 8'hC3});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick();
    t_first_burst();
    t_gap_and_count();
    t_patterns();
    t_snapshot();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule